// File: doc/BRIEF.md
# Three-Bit Pseudo-Random Pattern Source

This block is a three-flop linear feedback shift register intended as the stimulus source of a built-in self-test. A synchronous reset loads all ones. Each clock edge with the enable high then moves it one step along a fixed cycle of the seven nonzero three-bit values. The all-zero value never appears. The register shifts toward its most significant bit. The bit entering at the least significant end is the XOR of the two end bits.

The full state is available as a parallel output, so it can drive a small logic cloud under test directly. A single serial bit is also brought out for a scan-style consumer. When the enable is low the register keeps its value, so a test controller can pause the pattern stream.

Top module: `lfsr3_prsg`

## Requirements
- R1: A clock edge with `rst_i` high loads the state with 3'b111, regardless of its previous value.
- R2: A clock edge with `rst_i` low and `en_i` low leaves `state_o` unchanged.
- R3: A clock edge with `rst_i` low and `en_i` high moves to the next state: bit 2 takes old bit 1, bit 1 takes old bit 0, and bit 0 takes old bit 2 XOR old bit 0.
- R4: Starting from reset, enabled steps produce 111, 110, 101, 010, 100, 001, 011 (bit 2 written first), and the seventh step returns to 111.
- R5: Outside reset, `state_o` is never 3'b000.
- R6: With the default configuration, `serial_o` always equals `state_o[2]`.
- R7: Reset takes priority over enable. When both are high on an edge, the result is 3'b111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high, loads all ones |
| en_i | input | 1 | Advance enable, active high |
| state_o | output | 3 | Current register value |
| serial_o | output | 1 | Serial pattern bit, the most significant state bit |

## Verification
The state is the output, so a wrong feedback tap or a wrong shift direction shows on `state_o` at the first enabled edge after reset: 111 moves to something other than 110. A fault that only affects certain values shows within at most seven steps, because the bench walks the whole cycle and compares every state with the table. A hold fault or a reset-priority fault shows on the edge where the control pins are applied.

// File: rtl/lfsr3_pkg.sv
package lfsr3_pkg;
   localparam int unsigned PRSG_W = 3;
   typedef logic [PRSG_W-1:0] prsg_state_t;
   // Value loaded on reset
   localparam prsg_state_t PRSG_SEED = '1;
   // Bits XORed to form the incoming bit (bit 2 and bit 0)
   localparam prsg_state_t PRSG_TAPS = 3'b101;
endpackage

// File: rtl/lfsr3_feedback.sv
module lfsr3_feedback #(
   parameter int unsigned W = 3,
   parameter logic [W-1:0] TAPS = 3'b101
) (
   input  logic [W-1:0] cur_i,
   output logic         fb_o
);
   generate
      if (TAPS == '0) begin : g_bad_taps
         $error("lfsr3_feedback: tap mask must not be zero");
      end
   endgenerate

   always_comb begin
      fb_o = 1'b0;
      for (int i = 0; i < int'(W); i++) begin
         if (TAPS[i]) fb_o = fb_o ^ cur_i[i];
      end
   end
endmodule

// File: rtl/lfsr3_stage_reg.sv
module lfsr3_stage_reg #(
   parameter int unsigned W = 3,
   parameter logic [W-1:0] SEED = '1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   input  logic         fb_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("lfsr3_stage_reg: width must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("lfsr3_stage_reg: seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)     q_o <= SEED;
      else if (en_i) q_o <= {q_o[W-2:0], fb_i};
   end

   // R1
   seed_load_chk: assert property (@(posedge clk_i) rst_i |=> q_o == SEED);
   // R2
   hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> q_o == $past(q_o));
   // R5
   never_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      q_o != '0);
endmodule

// File: rtl/lfsr3_prsg.sv
module lfsr3_prsg
   import lfsr3_pkg::*;
#(
   parameter int unsigned W = PRSG_W,
   parameter logic [W-1:0] SEED = PRSG_SEED,
   parameter logic [W-1:0] TAPS = PRSG_TAPS,
   parameter bit SERIAL_FROM_MSB = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   output logic [W-1:0] state_o,
   output logic         serial_o
);
   localparam int unsigned MSB = W - 1;

   generate
      if (W != 3) begin : g_bad_width
         $error("lfsr3_prsg: only a three-bit register is supported");
      end
   endgenerate

   logic fb;

   lfsr3_feedback #(.W(W), .TAPS(TAPS)) fb_i (
      .cur_i (state_o),
      .fb_o  (fb)
   );

   lfsr3_stage_reg #(.W(W), .SEED(SEED)) reg_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (en_i),
      .fb_i  (fb),
      .q_o   (state_o)
   );

   generate
      if (SERIAL_FROM_MSB) begin : g_ser_msb
         assign serial_o = state_o[MSB];
      end else begin : g_ser_fb
         assign serial_o = fb;
      end
   endgenerate

   // R3
   step_shift_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |=> state_o == {$past(state_o[MSB-1:0]), $past(fb)});
   // R7
   reset_wins_chk: assert property (@(posedge clk_i)
      (rst_i && en_i) |=> state_o == SEED);
endmodule

// File: tb/lfsr3_prsg_tb.sv
module lfsr3_prsg_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [2:0] state;
   logic       ser;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam logic [2:0] EXP_TAB [0:6] =
      '{3'b111, 3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011};

   always #5 clk = ~clk;

   lfsr3_prsg dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .en_i     (en),
      .state_o  (state),
      .serial_o (ser)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive on the falling edge; after one rising edge, sample on the next falling edge.
   task automatic cyc(input bit r, input bit e);
      rst = r;
      en  = e;
      @(negedge clk);
   endtask

   task automatic t_reset;
      cyc(1'b1, 1'b0);
      chk(state == 3'b111, "R1 reset", int'(state), 7);
      chk(ser == state[2], "R6 serial after reset", int'(ser), int'(state[2]));
   endtask

   task automatic t_sequence;
      cyc(1'b1, 1'b0);
      for (int k = 1; k <= 7; k++) begin
         cyc(1'b0, 1'b1);
         chk(state == EXP_TAB[k % 7], "R4 sequence", int'(state), int'(EXP_TAB[k % 7]));
         chk(state != 3'b000, "R5 nonzero", int'(state), 1);
         chk(ser == state[2], "R6 serial", int'(ser), int'(state[2]));
      end
   endtask

   task automatic t_step_rule;
      logic [2:0] prev;
      cyc(1'b1, 1'b0);
      for (int k = 0; k < 10; k++) begin
         prev = state;
         cyc(1'b0, 1'b1);
         chk(state == {prev[1], prev[0], prev[2] ^ prev[0]}, "R3 step",
             int'(state), int'({prev[1], prev[0], prev[2] ^ prev[0]}));
      end
   endtask

   task automatic t_hold;
      logic [2:0] keep;
      cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b1);
      keep = state;
      for (int k = 0; k < 4; k++) begin
         cyc(1'b0, 1'b0);
         chk(state == keep, "R2 hold", int'(state), int'(keep));
      end
      cyc(1'b0, 1'b1);
      chk(state == EXP_TAB[3], "R2 resume", int'(state), int'(EXP_TAB[3]));
   endtask

   task automatic t_reset_priority;
      cyc(1'b1, 1'b0);
      for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1);
      chk(state == EXP_TAB[4], "R7 setup", int'(state), int'(EXP_TAB[4]));
      cyc(1'b1, 1'b1);
      chk(state == 3'b111, "R7 reset over enable", int'(state), 7);
      cyc(1'b1, 1'b1);
      chk(state == 3'b111, "R1 reset held", int'(state), 7);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_sequence();
      t_step_rule();
      t_hold();
      t_reset_priority();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule